// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block switches bytes between time slots on four serial streams of 128 channels each, giving 512 slots per frame. Every clock cycle handles one slot. The incoming byte for that slot is stored in a data memory at the slot's address. The same cycle reads a 16-bit connection word for the slot, and that word decides what goes out. The output is either a byte fetched from any source stream and channel, or a byte taken from the connection word itself.

Each connection word also carries several per-channel controls. One bit marks the channel as driven or idle, so the enable travels with the data as a flag. A second bit picks a constant delay of exactly one frame, or a variable delay as short as the slot order allows. A loopback bit stores the outgoing byte in place of the received byte for the same slot. A control bit is issued one channel period ahead of its slot.

The data memory has two banks that swap at every frame boundary. A frame-sync input restarts the slot count at any time. Connection words are loaded through a plain address, data and write-enable port, and a reset clears them all.

Top module: `tsi_switch`

## Requirements
- R1: While reset is held, `tx_byte`, `tx_en` and `cco` are all zero. Reset clears every connection word, so every slot stays idle until it is configured.
- R2: The slot index is {channel[6:0], stream[1:0]}: the stream changes fastest and the channel follows. A cycle with `fsync` high is slot 0. The index wraps from 511 to 0. The result for a slot is registered and appears on the outputs at the clock edge that ends that slot.
- R3: The connection word for a slot has these fields. Bits 8:7 hold the source stream and bits 6:0 hold the source channel. Bits 10:9 are reserved and must be written as zero. When bit 11 is 1 and bit 13 is 0, the slot outputs the byte stored for the source slot {channel, stream}.
- R4: When bits 11 and 13 are both 1, `tx_byte` is bits 7:0 of the connection word and `tx_en` is 1.
- R5: When bit 11 is 0, `tx_en` is 0 and `tx_byte` is 0 for that slot.
- R6: When bit 14 is 1 (constant delay), a switched slot outputs the source byte received exactly one frame earlier.
- R7: When bit 14 is 0 (variable delay), the delay depends on where the source slot falls. A source slot earlier in the same frame supplies its byte from the current frame. A source slot equal to the output slot passes the byte being received in that cycle. A later source slot supplies its byte from the previous frame.
- R8: When bit 15 is 1, the byte stored for that slot is the slot's own outgoing byte, which is 0 if the slot is disabled, and the received byte is dropped.
- R9: `cco` during the cycle after slot s carries bit 12 of the connection word of slot s+4 (mod 512). That is the same stream, one channel ahead, so within a channel the bits come out in stream order 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Marks the current cycle as slot 0 |
| rx_byte | input | 8 | Received byte for the current slot |
| cm_we | input | 1 | Connection word write enable |
| cm_addr | input | 9 | Slot index of the connection word to write |
| cm_wdata | input | 16 | Connection word value |
| tx_byte | output | 8 | Outgoing byte for the slot just ended |
| tx_en | output | 1 | Output-driven flag for the slot just ended |
| cco | output | 1 | Control bit for the same stream one channel ahead |

## Verification
The assertions assume the following about the inputs:
- Every connection word written keeps its reserved bits at zero.
- `fsync` is a single-cycle pulse, so the count after it always starts from slot 1.

The stimulus follows both rules: it writes only words built from the defined fields, and it pulses `fsync` for one cycle at the start of each run. Connection words are loaded only between runs, so the bank-swap and delay properties never see a word change in the middle of a measured frame.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int SW = 2,
  parameter int CW = 7,
  parameter int DW = 8,
  parameter int WW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [DW-1:0]     rx_byte,
  input  logic              cm_we,
  input  logic [SW+CW-1:0]  cm_addr,
  input  logic [WW-1:0]     cm_wdata,
  output logic [DW-1:0]     tx_byte,
  output logic              tx_en,
  output logic              cco
);
  localparam int AW    = SW + CW;
  localparam int SLOTS = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);
  localparam int B_LB = 15;
  localparam int B_VC = 14;
  localparam int B_PC = 13;
  localparam int B_CC = 12;
  localparam int B_OE = 11;

  logic [WW-1:0] cmem [SLOTS];
  logic [DW-1:0] dmem [2*SLOTS];

  logic [AW-1:0] cnt, cur, src, ahead;
  logic          bank_q, bank, rd_bank;
  logic [WW-1:0] cw;
  logic [DW-1:0] sw_byte, tx_next, wr_byte;

  assign cur     = fsync ? '0 : cnt;
  assign bank    = bank_q ^ (fsync && cnt != '0);
  assign cw      = cmem[cur];
  assign src     = {cw[CW-1:0], cw[CW+SW-1:CW]};
  assign ahead   = cur + AW'(1 << SW);
  assign rd_bank = (!cw[B_VC] && src < cur) ? bank : ~bank;
  assign sw_byte = (!cw[B_VC] && src == cur) ? rx_byte : dmem[{rd_bank, src}];
  assign tx_next = !cw[B_OE] ? '0 : (cw[B_PC] ? cw[DW-1:0] : sw_byte);
  assign wr_byte = cw[B_LB] ? tx_next : rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) cmem[i] <= '0;
    end else if (cm_we) begin
      cmem[cm_addr] <= cm_wdata;
    end
  end

  always_ff @(posedge clk) begin
    dmem[{bank, cur}] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      bank_q  <= 1'b0;
      tx_byte <= '0;
      tx_en   <= 1'b0;
      cco     <= 1'b0;
    end else begin
      cnt     <= cur + AW'(1);
      bank_q  <= bank ^ (cur == LAST);
      tx_byte <= tx_next;
      tx_en   <= cw[B_OE];
      cco     <= cmem[ahead][B_CC];
    end
  end

  p_resv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cm_we |-> cm_wdata[10:9] == 2'b00);

  p_fsync_realign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> cnt == AW'(1));

  p_bank_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == LAST) |=> bank_q != $past(bank_q));

  p_proc_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cw[B_OE] && cw[B_PC]) |=> (tx_en && tx_byte == $past(cw[DW-1:0])));

  p_idle_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cw[B_OE] |=> (!tx_en && tx_byte == '0));
endmodule

// File: tb/tb_tsi_switch.sv
`timescale 1ns/1ps
module tb_tsi_switch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        cm_we = 1'b0;
  logic [8:0]  cm_addr = '0;
  logic [15:0] cm_wdata = '0;
  logic [7:0]  tx_byte;
  logic        tx_en;
  logic        cco;

  tsi_switch dut (.clk(clk), .rst_n(rst_n), .fsync(fsync), .rx_byte(rx_byte),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
    .tx_byte(tx_byte), .tx_en(tx_en), .cco(cco));

  always #4 clk = ~clk;

  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {9'd0,   16'h38A5}, {9'd1,   16'h484B}, {9'd4,   16'h49FF}, {9'd5,   16'h0900},
    {9'd6,   16'h0901}, {9'd7,   16'h0864}, {9'd9,   16'h0100}, {9'd10,  16'hA83C},
    {9'd11,  16'h8000}, {9'd20,  16'h0902}, {9'd21,  16'h4982}, {9'd511, 16'h4800},
    {9'd510, 16'h1000}, {9'd3,   16'h3811}
  };

  int checks = 0;
  int fails  = 0;
  int frame_no = 0;
  logic [15:0] cmm [512];
  logic [7:0]  dmp [512];
  logic [7:0]  dmc [512];
  logic [7:0]  etx [512];
  bit          vp  [512];
  bit          vc  [512];
  bit          ev  [512];

  task automatic chk(bit ok, string req, int s, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s slot=%0d act=%0h exp=%0h", req, s, act, exp);
    end
  endtask

  function automatic logic [7:0] rxv(int f, int s);
    return 8'((s * 7 + f * 61 + 3) & 255);
  endfunction

  function automatic int srcof(logic [15:0] w);
    return {w[6:0], w[8:7]};
  endfunction

  function automatic string tag(int s);
    logic [15:0] w = cmm[s];
    if (s == 0) return "R2";
    if (!w[11]) return "R5";
    if (w[13]) return "R4";
    if (cmm[srcof(w)][15]) return "R8";
    if (s == 1 || s == 4) return "R3";
    if (w[14]) return "R6";
    return "R7";
  endfunction

  task automatic model_frame(int f);
    for (int s = 0; s < 512; s++) begin
      dmp[s] = dmc[s];
      vp[s]  = vc[s];
    end
    for (int s = 0; s < 512; s++) begin
      logic [15:0] w = cmm[s];
      int src = srcof(w);
      if (!w[11]) begin
        etx[s] = 8'h00; ev[s] = 1'b1;
      end else if (w[13]) begin
        etx[s] = w[7:0]; ev[s] = 1'b1;
      end else if (!w[14] && src == s) begin
        etx[s] = rxv(f, s); ev[s] = 1'b1;
      end else if (!w[14] && src < s) begin
        etx[s] = dmc[src]; ev[s] = vc[src];
      end else begin
        etx[s] = dmp[src]; ev[s] = vp[src];
      end
      if (w[15]) begin
        dmc[s] = etx[s]; vc[s] = ev[s];
      end else begin
        dmc[s] = rxv(f, s); vc[s] = 1'b1;
      end
    end
  endtask

  task automatic check_slot(int s);
    string t = tag(s);
    logic exp_cco = cmm[(s + 4) % 512][12];
    chk(tx_en == cmm[s][11], t, s, tx_en, cmm[s][11]);
    if (ev[s]) chk(tx_byte == etx[s], t, s, tx_byte, etx[s]);
    chk(cco == exp_cco, "R9", s, cco, exp_cco);
  endtask

  task automatic run(int nfr);
    for (int s = 0; s < 512; s++) begin
      vc[s] = 1'b0;
      dmc[s] = '0;
    end
    for (int i = 0; i <= nfr * 512; i++) begin
      @(negedge clk);
      if (i > 0) check_slot((i - 1) % 512);
      if (i < nfr * 512) begin
        int s = i % 512;
        if (s == 0) model_frame(frame_no);
        rx_byte = rxv(frame_no, s);
        fsync   = (i == 0);
        if (s == 511) frame_no++;
      end else begin
        fsync = 1'b0;
        rx_byte = '0;
      end
    end
  endtask

  task automatic write_cm(int a, logic [15:0] d);
    @(negedge clk);
    cm_we = 1'b1; cm_addr = 9'(a); cm_wdata = d;
    cmm[a] = d;
    @(negedge clk);
    cm_we = 1'b0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 512; s++) cmm[s] = '0;
    repeat (3) @(negedge clk);
    chk(tx_byte == 8'h00, "R1", -1, tx_byte, 0);
    chk(tx_en == 1'b0, "R1", -1, tx_en, 0);
    chk(cco == 1'b0, "R1", -1, cco, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx_en == 1'b0, "R1", -1, tx_en, 0);
    chk(cco == 1'b0, "R1", -1, cco, 0);

    for (int k = 0; k < NV; k++) write_cm(int'(VEC[k][24:16]), VEC[k][15:0]);
    run(3);

    for (int k = 0; k < NV; k++) begin
      logic [15:0] w = VEC[k][15:0];
      if (w[11] && !w[13]) write_cm(int'(VEC[k][24:16]), w ^ 16'h4000);
    end
    repeat (37) @(negedge clk);
    run(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule